// File: doc/BRIEF.md
# Video RAM Block-Copy DMA

This block copies a run of bytes from anywhere in the system address space into video RAM. Software first writes a source address and a destination address. A write to the control byte then starts the copy. The source is forced to a 16-byte boundary. The destination is reduced to a 16-byte-aligned offset inside the first 4 KiB of video RAM and is placed at the base of the video RAM window. The low seven bits of the control byte give the length in units of 16 bytes, so one transfer moves between 16 and 2048 bytes. The top bit of the control byte has no effect in this copy mode.

The block sends one read request per cycle to system memory. Memory returns the byte one cycle later, and the block writes that byte straight into video RAM. Bytes move in ascending order, and source and destination advance by the same offset. The control register reads back the byte that started the copy while the copy runs. When the last byte has been written, it reads 0xFF. Writes to the address registers during a copy are held for the next copy. A control write during a copy is discarded.

Top module: `vram_block_dma`

## Requirements
- R1: After reset, `busy`, `rd_req` and `vram_we` are low and `ctl_rdata` reads 0xFF.
- R2: The first read address of a transfer is the programmed source with bits 3:0 cleared (source AND 0xFFF0).
- R3: The byte at offset k is written to video RAM address 0x8000 + (destination AND 0x0FF0) + k, which always lies in 0x8000..0x9FFF.
- R4: A transfer moves exactly ((control AND 0x7F) + 1) × 16 bytes; control bit 7 does not change the count.
- R5: Offsets run upward from 0. The byte written at offset k equals the memory byte at source base + k.
- R6: A read request is issued on every cycle from the cycle after the start write until the last read. Each write follows its read by one cycle. `busy` is high for exactly length + 1 cycles, and the last write happens in the final busy cycle.
- R7: While busy, `ctl_rdata` returns the control byte that started the transfer. In the cycle that `busy` falls, it becomes 0xFF.
- R8: Source or destination writes made while busy do not alter the transfer in progress. They are used by the next transfer.
- R9: A control write while busy is ignored: it neither restarts nor lengthens the transfer, and it does not change `ctl_rdata`.
- R10: Source addresses wrap modulo 65536 when base + offset passes 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_we | input | 1 | Load source address register |
| src_wdata | input | 16 | Source address value |
| dst_we | input | 1 | Load destination address register |
| dst_wdata | input | 16 | Destination address value |
| ctl_we | input | 1 | Control write; starts a transfer when idle |
| ctl_wdata | input | 8 | Control byte; bits 6:0 are length units minus one |
| ctl_rdata | output | 8 | Control/status readback; 0xFF when complete |
| rd_req | output | 1 | Read request to system memory |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| vram_we | output | 1 | Video RAM write strobe |
| vram_addr | output | 16 | Video RAM write address |
| vram_wdata | output | 8 | Video RAM write data |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest case to reach is a register write that lands in the middle of a running transfer: new source and destination values and a second control byte, all arriving while bytes are still moving. The stimulus injects these writes a few cycles into a copy. It checks that the rest of that copy keeps the original addresses and length. It then starts a new copy without reprogramming the addresses, which shows that the held values take effect. Directed cases add a source that wraps past 0xFFFF, the largest destination offset combined with the longest length, and a control byte with bit 7 set. Seeded random transfers cover the rest of the space.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

  typedef enum logic [1:0] {
    VD_IDLE  = 2'd0,
    VD_COPY  = 2'd1,
    VD_DRAIN = 2'd2
  } vd_state_e;

  localparam logic [7:0] VD_DONE_CODE = 8'hFF;

endpackage

// File: rtl/vdma_cfg_regs.sv
module vdma_cfg_regs #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SRC_MASK = '1,
  parameter logic [ADDR_W-1:0] DST_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_we,
  input  logic [ADDR_W-1:0] src_wdata,
  input  logic              dst_we,
  input  logic [ADDR_W-1:0] dst_wdata,
  output logic [ADDR_W-1:0] src_aligned,
  output logic [ADDR_W-1:0] dst_aligned
);

  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;

  always_comb begin
    src_d = src_wdata;
    dst_d = dst_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (src_we) begin
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
    end else if (dst_we) begin
      dst_q <= dst_d;
    end
  end

  assign src_aligned = src_q & SRC_MASK;
  assign dst_aligned = dst_q & DST_MASK;

  // R2
  src_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_we |=> (src_aligned == ($past(src_wdata) & SRC_MASK)));

endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
  import vdma_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LEN_W     = 7,
  parameter int unsigned UNIT_LOG2 = 4,
  localparam int unsigned CTL_W    = LEN_W + 1,
  localparam int unsigned OFS_W    = LEN_W + UNIT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] dst_cur,
  output logic              busy,
  output logic [CTL_W-1:0]  status
);

  vd_state_e         state_q, state_d;
  logic [OFS_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [OFS_W-1:0]  last_q, last_d;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic              load;
  logic [CTL_W-1:0]  status_q, status_d;
  logic              status_en;
  logic              start;

  assign start = ctl_we && (state_q == VD_IDLE);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    load      = 1'b0;
    status_d  = status_q;
    status_en = 1'b0;
    last_d    = {ctl_wdata[LEN_W-1:0], {UNIT_LOG2{1'b1}}};
    unique case (state_q)
      VD_IDLE: begin
        if (start) begin
          state_d   = VD_COPY;
          cnt_d     = '0;
          cnt_en    = 1'b1;
          load      = 1'b1;
          status_d  = ctl_wdata;
          status_en = 1'b1;
        end
      end
      VD_COPY: begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
        if (cnt_q == last_q) begin
          state_d = VD_DRAIN;
        end
      end
      VD_DRAIN: begin
        state_d   = VD_IDLE;
        status_d  = CTL_W'(VD_DONE_CODE);
        status_en = 1'b1;
      end
      default: begin
        state_d = VD_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VD_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
    end else if (load) begin
      last_q <= last_d;
      src_q  <= src_base;
      dst_q  <= dst_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= CTL_W'(VD_DONE_CODE);
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  assign rd_req  = (state_q == VD_COPY);
  assign rd_addr = src_q + ADDR_W'(cnt_q);
  assign dst_cur = dst_q + ADDR_W'(cnt_q);
  assign busy    = (state_q != VD_IDLE);
  assign status  = status_q;

  // R5
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  // R2
  rd_first_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !$past(rd_req)) |-> (rd_addr[UNIT_LOG2-1:0] == '0));

  // R7
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (status == CTL_W'(VD_DONE_CODE)));

  // R9
  busy_ctl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && rd_req) |=> (busy && (status == $past(status))));

endmodule

// File: rtl/vdma_wr_stage.sv
module vdma_wr_stage #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] VRAM_BASE = 16'h8000,
  parameter int unsigned VRAM_SPAN = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_dst,
  input  logic [DATA_W-1:0] rd_data,
  output logic              vram_we,
  output logic [ADDR_W-1:0] vram_addr,
  output logic [DATA_W-1:0] vram_wdata
);

  localparam logic [ADDR_W:0] VRAM_END = {1'b0, VRAM_BASE} + (ADDR_W+1)'(VRAM_SPAN);

  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] ofs_q, ofs_d;

  always_comb begin
    vld_d = issue;
    ofs_d = issue_dst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (issue) begin
      ofs_q <= ofs_d;
    end
  end

  assign vram_we    = vld_q;
  assign vram_addr  = VRAM_BASE + ofs_q;
  assign vram_wdata = rd_data;

  // R3
  vram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> (({1'b0, vram_addr} >= {1'b0, VRAM_BASE}) &&
                 ({1'b0, vram_addr} < VRAM_END)));

  // R6
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> $past(issue));

endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LEN_W     = 7,
  parameter int unsigned UNIT_LOG2 = 4,
  parameter logic [ADDR_W-1:0] VRAM_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] DST_WINDOW = 16'h0FF0,
  parameter int unsigned VRAM_SPAN = 8192,
  localparam int unsigned CTL_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_we,
  input  logic [ADDR_W-1:0] src_wdata,
  input  logic              dst_we,
  input  logic [ADDR_W-1:0] dst_wdata,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              vram_we,
  output logic [ADDR_W-1:0] vram_addr,
  output logic [DATA_W-1:0] vram_wdata,
  output logic              busy
);

  localparam logic [ADDR_W-1:0] SRC_MASK = ~ADDR_W'((1 << UNIT_LOG2) - 1);
  localparam logic [ADDR_W-1:0] DST_MASK = DST_WINDOW & SRC_MASK;

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [ADDR_W-1:0] src_base, dst_base, dst_cur;

  vdma_cfg_regs #(
    .ADDR_W  (ADDR_W),
    .SRC_MASK(SRC_MASK),
    .DST_MASK(DST_MASK)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .src_we     (src_we),
    .src_wdata  (src_wdata),
    .dst_we     (dst_we),
    .dst_wdata  (dst_wdata),
    .src_aligned(src_base),
    .dst_aligned(dst_base)
  );

  vdma_seq #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .UNIT_LOG2(UNIT_LOG2)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .src_base (src_base),
    .dst_base (dst_base),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .dst_cur  (dst_cur),
    .busy     (busy),
    .status   (ctl_rdata)
  );

  vdma_wr_stage #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .VRAM_BASE(VRAM_BASE),
    .VRAM_SPAN(VRAM_SPAN)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .issue     (rd_req),
    .issue_dst (dst_cur),
    .rd_data   (rd_data),
    .vram_we   (vram_we),
    .vram_addr (vram_addr),
    .vram_wdata(vram_wdata)
  );

endmodule

// File: tb/vram_block_dma_bench.sv
module vram_block_dma_bench;

  logic        clk;
  logic        rst_n;
  logic        src_we, dst_we, ctl_we;
  logic [15:0] src_wdata, dst_wdata;
  logic [7:0]  ctl_wdata, ctl_rdata;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data;
  logic        vram_we;
  logic [15:0] vram_addr;
  logic [7:0]  vram_wdata;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [15:0] cur_src, cur_dst;
  logic [15:0] exp_src, exp_dst;
  int          exp_len;
  int          widx;

  vram_block_dma u_vram_block_dma (
    .clk(clk), .rst_n(rst_n),
    .src_we(src_we), .src_wdata(src_wdata),
    .dst_we(dst_we), .dst_wdata(dst_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
    .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (rd_req) rd_data <= mem_byte(rd_addr);
  end

  task automatic chk(input string req, input bit ok,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && vram_we) begin
      logic [15:0] sa, da;
      sa = exp_src + 16'(widx);
      da = exp_dst + 16'(widx);
      chk("R3 vram address", vram_addr == da, 32'(vram_addr), 32'(da));
      chk("R5 byte value", vram_wdata == mem_byte(sa), 32'(vram_wdata), 32'(mem_byte(sa)));
      widx++;
    end
  end

  task automatic set_cfg(input logic [15:0] s, input logic [15:0] d);
    @(negedge clk);
    src_we = 1'b1; src_wdata = s;
    dst_we = 1'b1; dst_wdata = d;
    @(negedge clk);
    src_we = 1'b0; dst_we = 1'b0;
    cur_src = s; cur_dst = d;
  endtask

  task automatic run_xfer(input logic [7:0] ctl, input bit poke);
    int cycles;
    logic [15:0] ns, nd;
    exp_len = ((int'(ctl) & 32'h7F) + 1) * 16;
    exp_src = cur_src & 16'hFFF0;
    exp_dst = 16'h8000 + (cur_dst & 16'h0FF0);
    widx = 0;
    ns = 16'($urandom);
    nd = 16'($urandom);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = ctl;
    @(negedge clk);
    ctl_we = 1'b0;
    chk("R2 first read address", rd_req && rd_addr == exp_src, 32'(rd_addr), 32'(exp_src));
    chk("R7 status while busy", ctl_rdata == ctl, 32'(ctl_rdata), 32'(ctl));
    cycles = 0;
    while (busy) begin
      cycles++;
      if (poke && cycles == 4) begin
        src_we = 1'b1; src_wdata = ns;
        dst_we = 1'b1; dst_wdata = nd;
        ctl_we = 1'b1; ctl_wdata = ~ctl;
        cur_src = ns; cur_dst = nd;
      end else begin
        src_we = 1'b0; dst_we = 1'b0; ctl_we = 1'b0;
      end
      if (poke && cycles == 6)
        chk("R9 status kept after busy control write", ctl_rdata == ctl,
            32'(ctl_rdata), 32'(ctl));
      if (cycles > 4000) break;
      @(negedge clk);
    end
    src_we = 1'b0; dst_we = 1'b0; ctl_we = 1'b0;
    chk("R6 busy cycle count", cycles == exp_len + 1, 32'(cycles), 32'(exp_len + 1));
    chk("R4 byte count", widx == exp_len, 32'(widx), 32'(exp_len));
    chk("R7 done code", ctl_rdata == 8'hFF, 32'(ctl_rdata), 32'hFF);
    if (poke)
      chk("R8 transfer unaffected by address writes", widx == exp_len,
          32'(widx), 32'(exp_len));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    src_we = 0; dst_we = 0; ctl_we = 0;
    src_wdata = 0; dst_wdata = 0; ctl_wdata = 0;
    rd_data = 0;
    cur_src = 0; cur_dst = 0;
    exp_src = 0; exp_dst = 16'h8000; exp_len = 0; widx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy after reset", busy == 1'b0, 32'(busy), 0);
    chk("R1 status after reset", ctl_rdata == 8'hFF, 32'(ctl_rdata), 32'hFF);
    chk("R1 no read after reset", rd_req == 1'b0, 32'(rd_req), 0);
    chk("R1 no write after reset", vram_we == 1'b0, 32'(vram_we), 0);

    // R2 R3 shortest transfer with unaligned addresses
    set_cfg(16'h1237, 16'h9ABC);
    run_xfer(8'h00, 1'b0);
    // R3 R4 largest destination offset and longest length
    set_cfg(16'h4000, 16'hFFFF);
    run_xfer(8'h7F, 1'b0);
    // R4 bit 7 ignored
    set_cfg(16'h2222, 16'h0101);
    run_xfer(8'h83, 1'b0);
    // R10 source wrap past 0xFFFF
    set_cfg(16'hFFF8, 16'h0040);
    run_xfer(8'h01, 1'b0);
    chk("R10 wrapped bytes seen", widx == 32, 32'(widx), 32);
    // R8 R9 register writes while busy, then reuse of held addresses
    set_cfg(16'h3456, 16'h0777);
    run_xfer(8'h02, 1'b1);
    run_xfer(8'h01, 1'b0);

    for (int i = 0; i < 12; i++) begin
      logic [7:0] c;
      c = 8'($urandom % 8) | (($urandom % 2) != 0 ? 8'h80 : 8'h00);
      if (i == 5) c = 8'h40;
      set_cfg(16'($urandom), 16'($urandom));
      run_xfer(c, (i % 3) == 0);
    end

    repeat (3) @(negedge clk);
    chk("R6 idle has no reads", rd_req == 1'b0 && busy == 1'b0, 32'(rd_req), 0);
    finished = 1;
    summary();
    $finish;
  end

endmodule